// File: doc/BRIEF.md
# Microcode Step Sequencer with Conditional Branch

This block is the step counter that walks a microcoded processor through the micro-steps of each instruction. On every clock edge it chooses the next step number from three inputs. A taken branch loads the target field. Otherwise, an end-of-instruction flag sends the counter back to zero. In all other cases the counter advances by one.

A 3-bit select field picks the branch condition from a small set of sources. Code 000 is never taken. Code 001 is taken when bit 0 of the operand shift register is clear. All other codes count as not taken.

The block also raises a flag that marks the last micro-step of an instruction. This flag is combinational on the current inputs. It is active when end-of-instruction is requested and no branch is taken, so a branch that loops back to repeat work never ends the instruction.

The microcode store supplies the select field, the target field and the end-of-instruction flag for the current step. The block holds no microcode of its own.

Top module: `useq_stepper`

## Requirements
- R1: When the selected condition is true, the step number on the following clock edge equals `br_target`, with no extra cycle spent on the branch.
- R2: When the selected condition is false and `end_instr` is 1, the step number on the following clock edge is 0.
- R3: When the selected condition is false and `end_instr` is 0, the step number advances by one on the following edge, and wraps from 15 to 0.
- R4: `last` equals `end_instr` AND NOT (condition true), evaluated in the same cycle from the current inputs.
- R5: Select code 3'b000 never takes the branch, whatever the value of `opnd_lsb`.
- R6: Select code 3'b001 takes the branch exactly when `opnd_lsb` is 0.
- R7: Select codes 3'b010 through 3'b111 never take the branch.
- R8: While `rst` is 1 at a clock edge, the step number becomes 0, and this overrides every other input.
- R9: A taken branch has priority over `end_instr`. The next step is `br_target`, not 0, and `last` stays 0 during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_sel | input | 3 | Branch condition select code |
| opnd_lsb | input | 1 | Bit 0 of the operand shift register |
| br_target | input | 4 | Step number loaded on a taken branch |
| end_instr | input | 1 | End-of-instruction request for the current step |
| step | output | 4 | Current micro-step number |
| last | output | 1 | Marks the final micro-step of the instruction |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge. They also assume that the first edge after power-up arrives with `rst` high, so that the step register holds a defined value before any `$past` comparison applies. The bench follows both rules. It raises `rst` before the first edge and drives every input at the falling edge, always with defined random or directed values. Its random select codes cover all eight values, including the undefined ones, so the property that treats those codes as false sees traffic.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int STEP_W_DEF = 4;
    localparam int SEL_W_DEF  = 3;

    // Condition select codes with a defined meaning; all others read false.
    localparam logic [SEL_W_DEF-1:0] SEL_NEVER     = 3'b000;
    localparam logic [SEL_W_DEF-1:0] SEL_LSB_CLEAR = 3'b001;

    typedef enum logic [1:0] {
        NXT_BRANCH = 2'd0,
        NXT_ZERO   = 2'd1,
        NXT_INCR   = 2'd2
    } nxt_kind_e;

    // Value of one condition source for a given select code.
    function automatic logic cond_source(input int code, input logic lsb);
        case (code)
            0:       return 1'b0;
            1:       return ~lsb;
            default: return 1'b0;
        endcase
    endfunction

    // Priority of the next-step choice: branch, then end reset, then count.
    function automatic nxt_kind_e pick_kind(input logic taken, input logic eoi);
        if (taken)    return NXT_BRANCH;
        else if (eoi) return NXT_ZERO;
        else          return NXT_INCR;
    endfunction

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
    import useq_pkg::*;
#(
    parameter int SEL_W = SEL_W_DEF
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             opnd_lsb,
    output logic             taken
);
    localparam int NUM_SRC = 1 << SEL_W;

    logic [NUM_SRC-1:0] src;

    // One source per select code; undefined codes tie to zero.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src[g] = cond_source(g, opnd_lsb);
    end

    assign taken = src[sel];
endmodule

// File: rtl/useq_next_step.sv
module useq_next_step
    import useq_pkg::*;
#(
    parameter int STEP_W = STEP_W_DEF
) (
    input  logic [STEP_W-1:0] cur,
    input  logic [STEP_W-1:0] target,
    input  logic              taken,
    input  logic              eoi,
    output logic [STEP_W-1:0] nxt,
    output logic              last
);
    nxt_kind_e kind;

    always_comb begin
        kind = pick_kind(taken, eoi);
        unique case (kind)
            NXT_BRANCH: nxt = target;
            NXT_ZERO:   nxt = '0;
            default:    nxt = cur + STEP_W'(1);
        endcase
        last = (kind == NXT_ZERO);
    end
endmodule

// File: rtl/useq_step_reg.sv
module useq_step_reg #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] d,
    output logic [STEP_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/useq_stepper.sv
module useq_stepper
    import useq_pkg::*;
#(
    parameter int STEP_W = STEP_W_DEF,
    parameter int SEL_W  = SEL_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic              opnd_lsb,
    input  logic [STEP_W-1:0] br_target,
    input  logic              end_instr,
    output logic [STEP_W-1:0] step,
    output logic              last
);
    logic              taken;
    logic [STEP_W-1:0] step_nxt;

    useq_cond_mux #(.SEL_W(SEL_W)) u_mux (
        .sel      (cond_sel),
        .opnd_lsb (opnd_lsb),
        .taken    (taken)
    );

    useq_next_step #(.STEP_W(STEP_W)) u_nxt (
        .cur    (step),
        .target (br_target),
        .taken  (taken),
        .eoi    (end_instr),
        .nxt    (step_nxt),
        .last   (last)
    );

    useq_step_reg #(.STEP_W(STEP_W)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (step_nxt),
        .q   (step)
    );
endmodule

// File: rtl/useq_stepper_chk.sv
module useq_stepper_chk #(
    parameter int STEP_W = 4,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  cond_sel,
    input logic              opnd_lsb,
    input logic [STEP_W-1:0] br_target,
    input logic              end_instr,
    input logic [STEP_W-1:0] step,
    input logic              last
);
    // Condition seen from the ports only.
    logic cond_true;
    assign cond_true = (cond_sel == SEL_W'(1)) && !opnd_lsb;

    p_branch_load_r1: assert property (@(posedge clk) disable iff (rst)
        cond_true |=> step == $past(br_target));

    p_end_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (!cond_true && end_instr) |=> step == '0);

    p_count_up_r3: assert property (@(posedge clk) disable iff (rst)
        (!cond_true && !end_instr) |=> step == STEP_W'($past(step) + 1'b1));

    p_last_flag_r4: assert property (@(posedge clk) disable iff (rst)
        last == (end_instr && !cond_true));

    p_never_sel_r5: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == '0 && !end_instr) |=> step == STEP_W'($past(step) + 1'b1));

    p_undef_sel_r7: assert property (@(posedge clk) disable iff (rst)
        (cond_sel > SEL_W'(1) && end_instr) |=> step == '0);

    p_reset_zero_r8: assert property (@(posedge clk)
        rst |=> step == '0);

    p_branch_over_end_r9: assert property (@(posedge clk) disable iff (rst)
        (cond_true && end_instr) |-> !last);
endmodule

bind useq_stepper useq_stepper_chk #(.STEP_W(STEP_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_useq_stepper.sv
`timescale 1ns/1ps
module tb_useq_stepper;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cond_sel;
    logic       opnd_lsb;
    logic [3:0] br_target;
    logic       end_instr;
    logic [3:0] step;
    logic       last;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;
    logic [3:0] model = 4'd0;

    always #2 clk = ~clk;

    useq_stepper dut (
        .clk(clk), .rst(rst), .cond_sel(cond_sel), .opnd_lsb(opnd_lsb),
        .br_target(br_target), .end_instr(end_instr), .step(step), .last(last)
    );

    function automatic bit exp_taken(input logic [2:0] s, input logic lsb);
        return (s == 3'b001) && (lsb == 1'b0);
    endfunction

    function automatic logic [3:0] exp_next(input logic [3:0] cur, input logic [2:0] s,
                                            input logic lsb, input logic [3:0] tgt,
                                            input logic eoi);
        if (exp_taken(s, lsb)) return tgt;
        if (eoi)               return 4'd0;
        return cur + 4'd1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, check last, then check step one edge later.
    task automatic step_once(input string req, input logic [2:0] s, input logic lsb,
                             input logic [3:0] tgt, input logic eoi);
        logic [3:0] nx;
        cond_sel = s; opnd_lsb = lsb; br_target = tgt; end_instr = eoi;
        #1;
        chk({req, " last"}, int'(last), int'(eoi && !exp_taken(s, lsb)));
        nx = exp_next(model, s, lsb, tgt, eoi);
        @(negedge clk);
        chk({req, " step"}, int'(step), int'(nx));
        model = nx;
    endtask

    initial begin
        rst = 1'b1; cond_sel = '0; opnd_lsb = 1'b0; br_target = '0; end_instr = 1'b0;
        void'($urandom(32'h5eed_1234));
        @(negedge clk); @(negedge clk);
        chk("R8 reset", int'(step), 0);
        rst = 1'b0;
        model = 4'd0;

        step_once("R3 count", 3'b000, 1'b1, 4'd9, 1'b0);
        step_once("R5 sel000 lsb0", 3'b000, 1'b0, 4'd12, 1'b0);
        step_once("R6 sel001 taken", 3'b001, 1'b0, 4'd7, 1'b0);
        step_once("R6 sel001 not taken", 3'b001, 1'b1, 4'd2, 1'b0);
        step_once("R1 branch", 3'b001, 1'b0, 4'd14, 1'b0);
        step_once("R3 to 15", 3'b000, 1'b0, 4'd0, 1'b0);
        step_once("R3 wrap", 3'b000, 1'b0, 4'd3, 1'b0);
        step_once("R9 branch over end", 3'b001, 1'b0, 4'd5, 1'b1);
        step_once("R2 end zero", 3'b001, 1'b1, 4'd5, 1'b1);
        step_once("R7 sel101", 3'b101, 1'b0, 4'd11, 1'b0);
        step_once("R7 sel111 end", 3'b111, 1'b0, 4'd11, 1'b1);
        step_once("R4 last", 3'b010, 1'b0, 4'd1, 1'b1);

        for (int i = 0; i < 1500; i++) begin
            logic [2:0] s   = 3'($urandom_range(0, 7));
            logic       lsb = 1'($urandom_range(0, 1));
            logic [3:0] tgt = 4'($urandom_range(0, 15));
            logic       eoi = ($urandom_range(0, 3) == 0);
            if (s > 3'b001)            step_once("R7 random", s, lsb, tgt, eoi);
            else if (exp_taken(s, lsb)) step_once("R1 random", s, lsb, tgt, eoi);
            else if (eoi)              step_once("R2 random", s, lsb, tgt, eoi);
            else                       step_once("R3 random", s, lsb, tgt, eoi);
        end

        // Reset mid-run overrides a taken branch.
        step_once("R1 pre-reset", 3'b001, 1'b0, 4'd10, 1'b0);
        rst = 1'b1; cond_sel = 3'b001; opnd_lsb = 1'b0; br_target = 4'd6;
        @(negedge clk);
        chk("R8 reset overrides branch", int'(step), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule